// File: doc/BRIEF.md
# Byte-Lane Memory Bank Decoder

This block sits between a CPU bus with a 16-bit data path and a memory built from byte-wide static RAM chips. The CPU presents a word address (its lowest line is A1; there is no A0), an active-low address strobe, a read/write line and two active-low byte strobes, one per data byte. Two chips side by side form one 16-bit bank: the upper chip holds data bits 15..8 and the lower chip bits 7..0.

The decoder splits the word address into a bank number (the top bits) and a chip-internal address (the remaining bits, sent to every chip). Each chip gets its own active-low chip enable, output enable and write enable. A chip is enabled only when its bank is addressed, its byte strobe is low and the address strobe is low, so a single-byte write touches one chip and a word write touches both. On a read the selected bank's enabled chips are steered onto the CPU read bus; a byte lane whose strobe is high reads as zero. An active-low acknowledge goes low at the first clock edge that sees the address strobe low and returns high as soon as the address strobe is released.

With the default parameters the address is 23 bits wide (A23..A1), each chip has a 22-bit address (4M bytes), and A23 picks one of two banks: four chips, 16 MB.

Top module: `membank_ctrl`

## Requirements
- R1: The top BANK_BITS bits of `cpu_addr` select the bank; no chip of any other bank is ever enabled, and at most one bank is active at a time.
- R2: `mem_addr` equals the low CHIP_AW bits of `cpu_addr` (`cpu_addr[0]` is A1) and is shared by every chip.
- R3: Chip index k = 2*bank + lane, lane 1 being the upper byte (bits 15..8) and lane 0 the lower byte (bits 7..0). `mem_ce_n[k]` is low exactly when bank is addressed, the lane's strobe (`cpu_uds_n` for lane 1, `cpu_lds_n` for lane 0) is low and `cpu_as_n` is low.
- R4: When `cpu_rw` is 0 (write), `mem_we_n[k]` equals `mem_ce_n[k]` and all `mem_oe_n` are high, so only strobed lanes are written.
- R5: When `cpu_rw` is 1 (read), `mem_oe_n[k]` equals `mem_ce_n[k]` and all `mem_we_n` are high; `cpu_rdata[15:8]` and `cpu_rdata[7:0]` carry the addressed bank's upper and lower chip outputs, and a lane that is not enabled reads 0.
- R6: `mem_wdata` carries `cpu_wdata` unchanged; bits 15..8 are the upper chips' data and bits 7..0 the lower chips'.
- R7: `cpu_dtack_n` goes low at the first rising clock edge at which `cpu_as_n` is sampled low, stays low while `cpu_as_n` stays low, and is high in the same cycle `cpu_as_n` is high.
- R8: While `rst_n` is low, and after reset until an address strobe is seen at a clock edge, `cpu_dtack_n` is high.
- R9: Both byte strobes low gives a 16-bit word access; exactly one low gives a single-byte access in that lane only; both high with the address strobe low enables no chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | ADDR_W | Word address, bit 0 is A1 |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_uds_n | input | 1 | Upper byte strobe (bits 15..8), active low |
| cpu_lds_n | input | 1 | Lower byte strobe (bits 7..0), active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 16 | Write data from the CPU |
| cpu_rdata | output | 16 | Read data to the CPU |
| cpu_dtack_n | output | 1 | Bus acknowledge, active low |
| mem_addr | output | CHIP_AW | Address shared by all chips |
| mem_ce_n | output | 2*BANKS | Chip enables, index 2*bank+lane |
| mem_oe_n | output | 2*BANKS | Output enables, index 2*bank+lane |
| mem_we_n | output | 2*BANKS | Write enables, index 2*bank+lane |
| mem_wdata | output | 16 | Write data to the chips |
| mem_rdata | input | 16*BANKS | Chip outputs, chip k in bits 8k+7..8k |

## Verification
The assertions assume the address strobe is high for at least one rising edge between bus cycles, so the acknowledge of one cycle cannot bleed into the next, and that address, direction and strobes are stable while the address strobe is low. The bench changes all bus inputs only at falling edges, asserts the strobe for exactly one rising edge per cycle and always idles a full clock between cycles. It sweeps every address of a small two-bank configuration with word writes, then upper-only and lower-only byte writes, and reads every address back with each of the three strobe combinations against a shadow memory.

// File: rtl/membank_pkg.sv
// Package: shared constants and chip numbering for the bank decoder.
// Assumes two byte lanes per bank; chip index = bank * lanes + lane.
package membank_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

    // Flat chip number for a bank and a byte lane.
    function automatic int chip_idx(input int bank, input int lane);
        return bank * LANES + lane;
    endfunction
endpackage

// File: rtl/bank_decode.sv
// Module: bank_decode
// Splits the CPU word address into a one-hot bank select and the
// address shared by all chips. Assumes ADDR_W > CHIP_AW.
module bank_decode #(
    parameter int ADDR_W  = 23,
    parameter int CHIP_AW = 22,
    localparam int BANK_BITS = ADDR_W - CHIP_AW,
    localparam int BANKS     = 1 << BANK_BITS
) (
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic [BANKS-1:0]   bank_hit,
    output logic [CHIP_AW-1:0] chip_addr
);
    // One-hot bank from the top address bits.
    always_comb begin
        bank_hit = '0;
        bank_hit[cpu_addr[ADDR_W-1:CHIP_AW]] = 1'b1;
    end

    assign chip_addr = cpu_addr[CHIP_AW-1:0];
endmodule

// File: rtl/lane_ctrl.sv
// Module: lane_ctrl
// Control strobes for one byte-wide chip. Enabled only when its bank is
// addressed, its byte strobe is low and the address strobe is low.
// Assumes rd = 1 for a read and 0 for a write.
module lane_ctrl (
    input  logic bank_sel,
    input  logic strobe_n,
    input  logic as_n,
    input  logic rd,
    output logic ce_n,
    output logic oe_n,
    output logic we_n
);
    logic enable;

    // Combined select for this chip.
    always_comb begin
        enable = bank_sel & ~strobe_n & ~as_n;
        ce_n   = ~enable;
        oe_n   = ~(enable & rd);
        we_n   = ~(enable & ~rd);
    end
endmodule

// File: rtl/read_steer.sv
// Module: read_steer
// Selects the addressed bank's two chip outputs onto the CPU read bus,
// zeroing any lane that is not strobed or any cycle that is not a read.
module read_steer
    import membank_pkg::*;
#(
    parameter int BANKS = 2,
    localparam int CHIPS = BANKS * LANES
) (
    input  logic [BANKS-1:0]        bank_hit,
    input  logic                    as_n,
    input  logic                    uds_n,
    input  logic                    lds_n,
    input  logic                    rd,
    input  logic [CHIPS*BYTE_W-1:0] mem_rdata,
    output logic [2*BYTE_W-1:0]     cpu_rdata
);
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;
    logic              rd_cycle;

    // Pick the addressed bank's chip outputs.
    always_comb begin
        hi_byte = '0;
        lo_byte = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_hit[b]) begin
                hi_byte = mem_rdata[chip_idx(b, LANE_HI)*BYTE_W +: BYTE_W];
                lo_byte = mem_rdata[chip_idx(b, LANE_LO)*BYTE_W +: BYTE_W];
            end
        end
    end

    // Gate each lane by its strobe and the read direction.
    always_comb begin
        rd_cycle  = rd & ~as_n;
        cpu_rdata = {(rd_cycle & ~uds_n) ? hi_byte : '0,
                     (rd_cycle & ~lds_n) ? lo_byte : '0};
    end
endmodule

// File: rtl/ack_gen.sv
// Module: ack_gen
// Bus acknowledge: low from the first clock edge that sees the address
// strobe low, released combinationally when the strobe goes high.
// Assumes the strobe idles high for at least one edge between cycles.
module ack_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    output logic dtack_n
);
    logic seen_q;

    // Remember that the strobe was low at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= ~as_n;
    end

    assign dtack_n = as_n | ~seen_q;

    // R7: a strobe held low across an edge is acknowledged.
    p_ack_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !$past(as_n) && $past(rst_n)) |-> !dtack_n);
    // R7: no acknowledge without a strobe.
    p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> dtack_n);
    // R8: first edge after reset never acknowledges.
    p_ack_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dtack_n);
endmodule

// File: rtl/membank_ctrl.sv
// Module: membank_ctrl (top)
// Memory bank decoder for a 16-bit CPU bus over byte-wide SRAM chips.
// Top address bits pick a bank of two chips; byte strobes pick lanes.
// Assumes bus inputs are stable while the address strobe is low.
module membank_ctrl
    import membank_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int CHIP_AW = 22,
    localparam int BANK_BITS = ADDR_W - CHIP_AW,
    localparam int BANKS     = 1 << BANK_BITS,
    localparam int CHIPS     = BANKS * LANES,
    localparam int DATA_W    = LANES * BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic                    cpu_as_n,
    input  logic                    cpu_uds_n,
    input  logic                    cpu_lds_n,
    input  logic                    cpu_rw,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    cpu_dtack_n,
    output logic [CHIP_AW-1:0]      mem_addr,
    output logic [CHIPS-1:0]        mem_ce_n,
    output logic [CHIPS-1:0]        mem_oe_n,
    output logic [CHIPS-1:0]        mem_we_n,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [CHIPS*BYTE_W-1:0] mem_rdata
);
    logic [BANKS-1:0] bank_hit;

    // Address split into bank select and chip address.
    bank_decode #(.ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW)) u_dec (
        .cpu_addr  (cpu_addr),
        .bank_hit  (bank_hit),
        .chip_addr (mem_addr)
    );

    // One control block per chip.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            localparam int IDX = chip_idx(b, ln);
            logic strobe_n;
            assign strobe_n = (ln == LANE_HI) ? cpu_uds_n : cpu_lds_n;

            lane_ctrl u_lane (
                .bank_sel (bank_hit[b]),
                .strobe_n (strobe_n),
                .as_n     (cpu_as_n),
                .rd       (cpu_rw),
                .ce_n     (mem_ce_n[IDX]),
                .oe_n     (mem_oe_n[IDX]),
                .we_n     (mem_we_n[IDX])
            );

            // R1: a chip is enabled only when its own bank is addressed.
            p_bank_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
                !mem_ce_n[IDX] |-> (cpu_addr[ADDR_W-1:CHIP_AW] == BANK_BITS'(b)));
            // R3: an enabled chip has its lane strobe low.
            p_lane_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !mem_ce_n[IDX] |-> !strobe_n);
        end
    end

    // Read data steering from the addressed bank.
    read_steer #(.BANKS(BANKS)) u_rd (
        .bank_hit  (bank_hit),
        .as_n      (cpu_as_n),
        .uds_n     (cpu_uds_n),
        .lds_n     (cpu_lds_n),
        .rd        (cpu_rw),
        .mem_rdata (mem_rdata),
        .cpu_rdata (cpu_rdata)
    );

    // Acknowledge timing.
    ack_gen u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (cpu_as_n),
        .dtack_n (cpu_dtack_n)
    );

    assign mem_wdata = cpu_wdata;

    // R1: never more than one bank's pair of chips enabled.
    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= LANES);
    // R3: no chip enabled without the address strobe.
    p_need_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_as_n |-> (&mem_ce_n));
    // R4: no write enable during a read.
    p_no_we_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rw |-> (&mem_we_n));
    // R5: no output enable during a write.
    p_no_oe_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> (&mem_oe_n));
    // R9: with both byte strobes high no chip is enabled.
    p_no_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_uds_n && cpu_lds_n) |-> (&mem_ce_n));
endmodule

// File: tb/membank_ctrl_test.sv
// Bench: two-bank, 16-word configuration; behavioural chips; shadow memory.
module membank_ctrl_test;
    localparam int AW = 5;
    localparam int CW = 4;
    localparam int NCH = 4;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [AW-1:0]    cpu_addr = '0;
    logic             cpu_as_n = 1'b1, cpu_uds_n = 1'b1, cpu_lds_n = 1'b1, cpu_rw = 1'b1;
    logic [15:0]      cpu_wdata = '0;
    logic [15:0]      cpu_rdata;
    logic             cpu_dtack_n;
    logic [CW-1:0]    mem_addr;
    logic [NCH-1:0]   mem_ce_n, mem_oe_n, mem_we_n;
    logic [15:0]      mem_wdata;
    logic [NCH*8-1:0] mem_rdata;

    logic [7:0] arr    [NCH][DEPTH];
    logic [7:0] shadow [NCH][DEPTH];
    int n_checks = 0;
    int n_fail = 0;

    membank_ctrl #(.ADDR_W(AW), .CHIP_AW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_as_n(cpu_as_n),
        .cpu_uds_n(cpu_uds_n), .cpu_lds_n(cpu_lds_n), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_dtack_n(cpu_dtack_n),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural chips: write at the clock edge, read always visible.
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++)
            if (!mem_ce_n[i] && !mem_we_n[i])
                arr[i][mem_addr] <= (i % 2 == 1) ? mem_wdata[15:8] : mem_wdata[7:0];
    end
    always_comb begin
        for (int i = 0; i < NCH; i++) mem_rdata[i*8 +: 8] = arr[i][mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One bus cycle: strobe for one rising edge, then idle one cycle.
    task automatic bus_cycle(input logic [AW-1:0] a, input bit rd, input bit u, input bit l,
                             input logic [15:0] wd);
        logic [NCH-1:0] exp_ce;
        logic [15:0]    exp_rd;
        int             bk;
        bk = int'(a[AW-1]);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rd; cpu_uds_n = !u; cpu_lds_n = !l;
        cpu_wdata = wd; cpu_as_n = 1'b0;
        #2;
        exp_ce = '1;
        if (u) exp_ce[bk*2+1] = 1'b0;
        if (l) exp_ce[bk*2]   = 1'b0;
        chk(mem_ce_n == exp_ce, "R1 R3 R9 chip enables", 32'(mem_ce_n), 32'(exp_ce));
        chk(mem_addr == a[CW-1:0], "R2 chip address", 32'(mem_addr), 32'(a[CW-1:0]));
        if (rd) begin
            chk(mem_oe_n == exp_ce && mem_we_n == '1, "R5 read enables",
                {mem_oe_n, mem_we_n}, {exp_ce, 4'hF});
        end else begin
            chk(mem_we_n == exp_ce && mem_oe_n == '1, "R4 write enables",
                {mem_oe_n, mem_we_n}, {4'hF, exp_ce});
            chk(mem_wdata == wd, "R6 write data", 32'(mem_wdata), 32'(wd));
        end
        chk(cpu_dtack_n == 1'b1, "R7 no ack before edge", 32'(cpu_dtack_n), 1);
        @(negedge clk);
        chk(cpu_dtack_n == 1'b0, "R7 ack after edge", 32'(cpu_dtack_n), 0);
        if (rd) begin
            exp_rd = {u ? shadow[bk*2+1][a[CW-1:0]] : 8'h00,
                      l ? shadow[bk*2][a[CW-1:0]]   : 8'h00};
            chk(cpu_rdata == exp_rd, (u && l) ? "R5 word read" : "R9 byte read",
                32'(cpu_rdata), 32'(exp_rd));
        end else begin
            if (u) shadow[bk*2+1][a[CW-1:0]] = wd[15:8];
            if (l) shadow[bk*2][a[CW-1:0]]   = wd[7:0];
        end
        cpu_as_n = 1'b1; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1;
        #2;
        chk(cpu_dtack_n == 1'b1, "R7 release", 32'(cpu_dtack_n), 1);
        chk(mem_ce_n == '1, "R3 idle enables", 32'(mem_ce_n), 32'hF);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < NCH; i++)
            for (int j = 0; j < DEPTH; j++) begin
                arr[i][j] = 8'h00;
                shadow[i][j] = 8'h00;
            end
        // R8: acknowledge stays high during reset even with the strobe low.
        cpu_as_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cpu_dtack_n == 1'b1, "R8 ack in reset", 32'(cpu_dtack_n), 1);
        cpu_as_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_dtack_n == 1'b1, "R8 ack after reset", 32'(cpu_dtack_n), 1);

        // R9: address strobe with no byte strobe enables nothing.
        cpu_as_n = 1'b0;
        #2;
        chk(mem_ce_n == '1, "R9 no lane", 32'(mem_ce_n), 32'hF);
        @(negedge clk);
        chk(cpu_dtack_n == 1'b0, "R7 ack without lanes", 32'(cpu_dtack_n), 0);
        // R3: byte strobes without the address strobe enable nothing.
        cpu_as_n = 1'b1; cpu_uds_n = 1'b0; cpu_lds_n = 1'b0;
        #2;
        chk(mem_ce_n == '1, "R3 no address strobe", 32'(mem_ce_n), 32'hF);
        cpu_uds_n = 1'b1; cpu_lds_n = 1'b1;

        // Word writes over every address.
        for (int a = 0; a < 2*DEPTH; a++)
            bus_cycle(AW'(a), 1'b0, 1'b1, 1'b1, {8'(a*3+1), 8'(a*5+2)});
        // Byte writes: upper lane on even, lower lane on odd addresses.
        for (int a = 0; a < 2*DEPTH; a++) begin
            if (a % 2 == 0) bus_cycle(AW'(a), 1'b0, 1'b1, 1'b0, {8'(8'hA0 ^ a), 8'hEE});
            else            bus_cycle(AW'(a), 1'b0, 1'b0, 1'b1, {8'hEE, 8'(8'h50 ^ a)});
        end
        // Read back with word, upper-only and lower-only strobes.
        for (int a = 0; a < 2*DEPTH; a++) begin
            bus_cycle(AW'(a), 1'b1, 1'b1, 1'b1, 16'h0);
            bus_cycle(AW'(a), 1'b1, 1'b1, 1'b0, 16'h0);
            bus_cycle(AW'(a), 1'b1, 1'b0, 1'b1, 16'h0);
        end
        report();
    end
endmodule